// File: doc/BRIEF.md
# Set/Clear Control and Interrupt Register Block

This block holds three 15-bit control words behind a 16-bit memory-mapped bus: a DMA control word, an interrupt enable mask and an interrupt request word. A write never loads a value directly. Bit 15 of the write data picks the operation. When it is 1, every register bit whose data bit in 14:0 is 1 is set. When it is 0, those bits are cleared. Bits written as 0 keep their value. Software can therefore change a single flag without a read-modify-write sequence.

A read of the DMA control word returns the stored bits ORed with a live status word from a blitter engine. Hardware interrupt sources raise request bits through a 14-bit pulse input. The interrupt output is high when the master enable is set and some request is both pending and enabled. Read data is combinational from the current register state and the current status input. A write takes effect at the next rising clock edge.

Top module: `ctl_setclr_regs`

## Requirements
- R1: A write whose data bit 15 is 1 sets, at the next clock edge, each register bit whose data bit in 14:0 is 1. Every other bit of that register is left unchanged.
- R2: A write whose data bit 15 is 0 clears, at the next clock edge, each register bit whose data bit in 14:0 is 1. Every other bit of that register is left unchanged.
- R3: A write at byte offset 0x096 updates the DMA control word. A read at byte offset 0x002 returns, in the same cycle, {0, DMA control[14:0]} ORed with the 16-bit `blit_status` input.
- R4: A write at byte offset 0x09A updates the interrupt enable mask. A write at byte offset 0x09C updates the interrupt request word.
- R5: Address bit 0 is ignored. Decode uses address bits 11:1 together with the access direction.
- R6: `irq` is 1 exactly when enable bit 14 is 1 and at least one index i in 0..13 has both request bit i and enable bit i equal to 1. `irq` follows a register change in the cycle after the write.
- R7: A 1 on `hw_req[i]` sets request bit i at the next clock edge. A clearing write to the same bit in the same cycle still leaves the bit set.
- R8: After reset all three registers are 0. Bit 15 of each stored register always reads as 0.
- R9: A read of any offset other than 0x002 returns 0, and `rd_data` is 0 whenever `rd_en` is low. A write to any offset other than the three write offsets changes no register.
- R10: Direction matters. A read at 0x096 returns 0, and a write at 0x002 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| rd_data | output | 16 | Read data, combinational |
| blit_status | input | 16 | Live blitter status merged into the DMA control readback |
| hw_req | input | 14 | Per-bit pulses that raise interrupt request bits |
| irq | output | 1 | Interrupt output |

## Verification
Directed sequences cover several cases. Sets and clears of overlapping masks show that R1 and R2 leave untouched bits alone, which a plain load would not. Odd addresses separate correct bit-0 masking from full-address decode. A write to the read offset, and a read from the write offset, show whether decode uses the direction. Further directed cases toggle the master enable with a pending request, and collide a hardware pulse with a clearing write; these separate enable gating and pulse priority from simpler OR logic. Seeded random traffic then mixes mapped, aliased and unmapped addresses with random data, status and pulses. Each cycle is compared against a bench model of the three registers.

// File: rtl/ctl_setclr_pkg.sv
package ctl_setclr_pkg;
    localparam int WORD_W = 16;
    localparam int VAL_W  = WORD_W - 1;
    localparam int SRC_W  = 14;
    localparam int ADDR_W = 12;
    localparam int MASTER_BIT = SRC_W;

    typedef logic [ADDR_W-2:0] word_addr_t;

    localparam word_addr_t OFS_DMA_RD = word_addr_t'(12'h002 >> 1);
    localparam word_addr_t OFS_DMA_WR = word_addr_t'(12'h096 >> 1);
    localparam word_addr_t OFS_EN_WR  = word_addr_t'(12'h09a >> 1);
    localparam word_addr_t OFS_REQ_WR = word_addr_t'(12'h09c >> 1);

    typedef struct packed {
        logic dma_rd;
        logic dma_wr;
        logic en_wr;
        logic req_wr;
    } sel_t;

    function automatic logic [VAL_W-1:0] apply_setclr(
        input logic [VAL_W-1:0]  cur,
        input logic [WORD_W-1:0] data
    );
        if (data[WORD_W-1])
            return cur | data[VAL_W-1:0];
        else
            return cur & ~data[VAL_W-1:0];
    endfunction
endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_setclr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output sel_t              sel
);
    word_addr_t waddr;
    logic       unused_addr_lsb;

    assign waddr           = addr[ADDR_W-1:1];
    assign unused_addr_lsb = addr[0];

    always_comb begin
        sel        = '0;
        sel.dma_rd = rd_en && (waddr == OFS_DMA_RD);
        sel.dma_wr = wr_en && (waddr == OFS_DMA_WR);
        sel.en_wr  = wr_en && (waddr == OFS_EN_WR);
        sel.req_wr = wr_en && (waddr == OFS_REQ_WR);
    end

    always_comb begin
        assert_one_target_R10: assert ($onehot0({sel.dma_wr, sel.en_wr, sel.req_wr}));
    end
endmodule

// File: rtl/ctl_setclr_reg.sv
module ctl_setclr_reg
    import ctl_setclr_pkg::*;
#(
    parameter int WIDTH = VAL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WIDTH-1:0]  hw_set,
    output logic [WIDTH-1:0]  q
);
    logic [WIDTH-1:0] upd;

    always_comb begin
        upd = wr_en ? apply_setclr(q, wr_data) : q;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= upd[i] | hw_set[i];
        end
    end

    assert_set_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[WORD_W-1]) |=>
            ((q & $past(wr_data[WIDTH-1:0])) == $past(wr_data[WIDTH-1:0])));

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[WORD_W-1]) |=>
            ((q & $past(wr_data[WIDTH-1:0]) & ~$past(hw_set)) == '0));

    assert_keep_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=>
            (((q ^ $past(q)) & ~$past(wr_data[WIDTH-1:0]) & ~$past(hw_set)) == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && hw_set == '0) |=> $stable(q));

    assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/ctl_irq.sv
module ctl_irq
    import ctl_setclr_pkg::*;
(
    input  logic [VAL_W-1:0] enable,
    input  logic [VAL_W-1:0] request,
    output logic             irq
);
    logic unused_req_top;

    assign unused_req_top = request[MASTER_BIT];

    always_comb begin
        irq = enable[MASTER_BIT] && ((enable[SRC_W-1:0] & request[SRC_W-1:0]) != '0);
    end
endmodule

// File: rtl/ctl_setclr_regs.sv
module ctl_setclr_regs
    import ctl_setclr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [WORD_W-1:0] blit_status,
    input  logic [SRC_W-1:0]  hw_req,
    output logic              irq
);
    sel_t             sel;
    logic [VAL_W-1:0] dma_q;
    logic [VAL_W-1:0] en_q;
    logic [VAL_W-1:0] req_q;
    logic [VAL_W-1:0] req_hw;

    assign req_hw = {{(VAL_W-SRC_W){1'b0}}, hw_req};

    ctl_decode u_decode (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .sel   (sel)
    );

    ctl_setclr_reg #(.WIDTH(VAL_W)) u_dma (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sel.dma_wr),
        .wr_data (wr_data),
        .hw_set  ('0),
        .q       (dma_q)
    );

    ctl_setclr_reg #(.WIDTH(VAL_W)) u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sel.en_wr),
        .wr_data (wr_data),
        .hw_set  ('0),
        .q       (en_q)
    );

    ctl_setclr_reg #(.WIDTH(VAL_W)) u_req (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sel.req_wr),
        .wr_data (wr_data),
        .hw_set  (req_hw),
        .q       (req_q)
    );

    ctl_irq u_irq (
        .enable  (en_q),
        .request (req_q),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        if (sel.dma_rd)
            rd_data = {1'b0, dma_q} | blit_status;
    end

    assert_rd_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));

    assert_irq_master_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> en_q[MASTER_BIT]);

    assert_status_merge_R3: assert property (@(posedge clk) disable iff (rst)
        sel.dma_rd |-> ((rd_data & blit_status) == blit_status));
endmodule

// File: tb/ctl_setclr_regs_test.sv
module ctl_setclr_regs_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] addr;
    logic        wr_en;
    logic        rd_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic [15:0] blit_status;
    logic [13:0] hw_req;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [14:0] m_dma, m_en, m_req;

    always #4 clk = ~clk;

    ctl_setclr_regs uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .blit_status(blit_status),
        .hw_req(hw_req), .irq(irq)
    );

    function automatic logic [14:0] sc(input logic [14:0] cur, input logic [15:0] d);
        return d[15] ? (cur | d[14:0]) : (cur & ~d[14:0]);
    endfunction

    function automatic logic exp_irq();
        return m_en[14] && ((m_en[13:0] & m_req[13:0]) != 0);
    endfunction

    function automatic logic [15:0] exp_rd();
        if (rd_en && addr[11:1] == 11'h001) return {1'b0, m_dma} | blit_status;
        return 16'h0;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one access at the falling edge, check the combinational outputs
    // against the model's current state, then advance the model at the rising edge.
    task automatic step(input logic [11:0] a, input logic w, input logic r,
                        input logic [15:0] d, input logic [15:0] st, input logic [13:0] hw,
                        input string tag);
        @(negedge clk);
        addr = a; wr_en = w; rd_en = r; wr_data = d; blit_status = st; hw_req = hw;
        #1;
        check({tag, " rd_data"}, rd_data, exp_rd());
        check("R6 irq", {15'h0, irq}, {15'h0, exp_irq()});
        if (w && a[11:1] == 11'h04b) m_dma = sc(m_dma, d);
        if (w && a[11:1] == 11'h04d) m_en  = sc(m_en, d);
        if (w && a[11:1] == 11'h04e) m_req = sc(m_req, d);
        m_req = m_req | {1'b0, hw};
        @(posedge clk);
    endtask

    task automatic rd_dma(input string tag);
        step(12'h002, 1'b0, 1'b1, 16'h0, 16'h0, 14'h0, tag);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] picks [9];
        void'($urandom(32'd5151));
        picks = '{12'h002, 12'h003, 12'h096, 12'h097, 12'h09a, 12'h09b, 12'h09c, 12'h09d, 12'h000};
        rst = 1'b1; addr = 0; wr_en = 0; rd_en = 0; wr_data = 0; blit_status = 0; hw_req = 0;
        m_dma = 0; m_en = 0; m_req = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R8: reset state and bit 15 reads 0
        rd_dma("R8 reset");
        step(12'h096, 1, 0, 16'hffff, 0, 0, "R8");
        rd_dma("R8 msb zero");
        // R2: clear a subset, others unchanged
        step(12'h096, 1, 0, 16'h00f0, 0, 0, "R2");
        rd_dma("R2 clear");
        // R1: set a subset over existing bits
        step(12'h096, 1, 0, 16'h0000, 0, 0, "R2");
        step(12'h096, 1, 0, 16'h7fff, 0, 0, "R2");
        step(12'h096, 1, 0, 16'h8101, 0, 0, "R1");
        step(12'h096, 1, 0, 16'h8030, 0, 0, "R1");
        rd_dma("R1 set");
        // R3: status merge, bit 15 of status passes through
        step(12'h002, 0, 1, 0, 16'h8c00, 0, "R3 merge");
        // R5: odd addresses alias
        step(12'h097, 1, 0, 16'h8002, 0, 0, "R5");
        step(12'h003, 0, 1, 0, 0, 0, "R5 odd read");
        // R10: write at read offset ignored, read at write offset returns 0
        step(12'h002, 1, 0, 16'h7fff, 0, 0, "R10");
        rd_dma("R10 write ignored");
        step(12'h096, 0, 1, 0, 16'h1234, 0, "R10 read wr offset");
        // R9: unmapped write ignored, unmapped read zero, idle read zero
        step(12'h0a0, 1, 0, 16'h7fff, 0, 0, "R9");
        rd_dma("R9 unmapped write");
        step(12'h004, 0, 1, 0, 16'hffff, 0, "R9 unmapped read");
        step(12'h002, 0, 0, 0, 16'hffff, 0, "R9 idle read");
        // R4/R6: enable and request through irq
        step(12'h09c, 1, 0, 16'h8004, 0, 0, "R4");
        step(12'h09a, 1, 0, 16'h8004, 0, 0, "R4");
        step(12'h09a, 1, 0, 16'hc000, 0, 0, "R6");
        step(12'h000, 0, 0, 0, 0, 0, "R6 master on");
        step(12'h09a, 1, 0, 16'h4000, 0, 0, "R6");
        step(12'h000, 0, 0, 0, 0, 0, "R6 master off");
        step(12'h09a, 1, 0, 16'h4000 | 16'h8000, 0, 0, "R6");
        step(12'h09c, 1, 0, 16'h0004, 0, 0, "R4");
        step(12'h000, 0, 0, 0, 0, 0, "R4 request cleared");
        // R7: pulse against clearing write on same bit
        step(12'h09c, 1, 0, 16'h0004, 0, 14'h0004, "R7");
        step(12'h000, 0, 0, 0, 0, 0, "R7 pulse wins");
        step(12'h09c, 1, 0, 16'h3fff, 0, 0, "R7");
        step(12'h000, 0, 0, 0, 0, 14'h2000, "R7");
        step(12'h09a, 1, 0, 16'h9fff, 0, 0, "R7");
        step(12'h000, 0, 0, 0, 0, 0, "R7 pulse raised");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            logic [13:0] hw;
            a  = ($urandom % 5 == 0) ? 12'($urandom) : picks[$urandom % 9];
            hw = ($urandom % 8 == 0) ? 14'(1 << ($urandom % 14)) : 14'h0;
            step(a, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), hw,
                 (a[11:1] == 11'h001) ? "R3 random" : "R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule